// File: doc/BRIEF.md
# Four-to-one width packing dual-clock FIFO

This block carries a stream of 9-bit words from one clock domain to another and hands it out as 36-bit words. The producer pushes narrow words on its own clock with a write request and must hold off while the full flag is high. The consumer pulls wide words on an unrelated clock with a read request while the empty flag is low. Each wide word is made of four narrow words that were written one after another. The earliest of the four occupies the lowest lane.

Storage holds 8192 narrow words, which is 2048 wide words. The write pointer counts narrow words and the read pointer counts wide words. Only whole wide words cross to the read side: the write pointer is sent as a Gray-coded wide-word count, and the read pointer is sent back as a Gray-coded count. Each goes through a chain of flip-flops whose length is a parameter (default 5). The read port registers its output: data appears one read clock after the request is accepted.

A single asynchronous clear resets both sides. It is asserted at once and released in step with each clock. On the write side, writes stay blocked for a few more cycles after release. Requests that would overflow or underflow are dropped.

Top module: `lane_pack_fifo`

## Requirements
- R1: The four narrow words that form one wide word land in lanes in write order. The first goes to bits [8:0], the second to [17:9], the third to [26:18] and the fourth to [35:27]. Wide words leave in the order they were filled.
- R2: `rd_data` changes only on the read-clock edge that accepts a read (`rd_en` high while `rd_empty` is low). It then shows the oldest complete wide word. At all other times it holds its value.
- R3: A write request while `wr_full` is high is dropped. Memory and pointers are left as they were, so the stored data read out afterwards is unchanged.
- R4: A read request while `rd_empty` is high is dropped. `rd_data` holds, and the next real read returns the next unread wide word.
- R5: `rd_empty` stays high until all four narrow words of a wide word have been written. Three narrow words alone never make data readable.
- R6: With no reads, `wr_full` rises right after the 8192nd accepted narrow write, and not before.
- R7: While `clr` is high and for a few write cycles after it falls, `wr_full` is high and writes are dropped. After a clear, `rd_empty` is high and `rd_data` is zero, and any earlier contents are discarded.
- R8: After a wide word is read from a full FIFO, `wr_full` falls once the read pointer has crossed over. Exactly four more narrow writes then make it rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| clr | input | 1 | Asynchronous clear, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | 9 | Narrow write word |
| wr_full | output | 1 | No room for a narrow word, or clear in progress |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered wide read word |
| rd_empty | output | 1 | No complete wide word available |

## Verification
Three of four narrow words are written and then left alone for many read cycles. A design that published partial wide words would drop `rd_empty` here and return a word with garbage lanes. The FIFO is filled to the exact narrow capacity and then hit with extra write requests. A full flag off by one lane, or missing overflow protection, would show up as a corrupted or shifted word during the full drain. Reads are issued while the FIFO is empty, and writes are driven during and just after a clear. A design without those guards would advance a pointer and return a stale or shifted word later. Random concurrent traffic on unrelated clocks then checks lane order and word order against a reference queue.

// File: rtl/lane_pack_pkg.sv
package lane_pack_pkg;

    parameter int NARROW_W    = 9;
    parameter int LANES       = 4;
    parameter int NARROW_AW   = 13;

    localparam int WIDE_W      = NARROW_W * LANES;
    localparam int LANE_BITS   = $clog2(LANES);
    localparam int WIDE_AW     = NARROW_AW - LANE_BITS;
    localparam int WIDE_DEPTH  = 1 << WIDE_AW;
    localparam int NARROW_DEPTH = 1 << NARROW_AW;

    // narrow pointer carries one wrap bit above the narrow address
    typedef logic [NARROW_AW:0] nptr_t;
    // wide pointer carries one wrap bit above the wide address
    typedef logic [WIDE_AW:0]   wptr_t;

    typedef struct packed {
        logic                 en;
        logic [WIDE_AW-1:0]   row;
        logic [LANE_BITS-1:0] lane;
        logic [NARROW_W-1:0]  data;
    } lane_wr_t;

    function automatic wptr_t to_gray(input wptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic wptr_t from_gray(input wptr_t g);
        wptr_t b;
        b[WIDE_AW] = g[WIDE_AW];
        for (int i = WIDE_AW - 1; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/lpf_rst_sync.sv
module lpf_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    output logic srst
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or posedge arst) begin
                if (arst) sh <= 1'b1;
                else      sh <= 1'b0;
            end
        end else begin : g_many
            always_ff @(posedge clk or posedge arst) begin
                if (arst) sh <= '1;
                else      sh <= {sh[STAGES-2:0], 1'b0};
            end
        end
    endgenerate

    assign srst = sh[STAGES-1];
endmodule

// File: rtl/lpf_ptr_sync.sv
module lpf_ptr_sync
    import lane_pack_pkg::*;
#(
    parameter int STAGES = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  wptr_t d,
    output wptr_t q
);
    logic [STAGES-1:0][WIDE_AW:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lpf_wr_side.sv
module lpf_wr_side
    import lane_pack_pkg::*;
#(
    parameter int HOLD_CYCLES = 4
) (
    input  logic                wr_clk,
    input  logic                wr_rst,
    input  logic                wr_en,
    input  logic [NARROW_W-1:0] wr_data,
    input  wptr_t               rq_gray,
    output logic                full,
    output lane_wr_t            beat,
    output wptr_t               wq_gray
);
    localparam int HC_W = $clog2(HOLD_CYCLES + 1);

    nptr_t           wptr;
    nptr_t           wnext;
    nptr_t           level;
    wptr_t           rq_bin;
    logic [HC_W-1:0] hold_cnt;
    logic            ready;
    logic            full_core;
    logic            accept;

    assign rq_bin    = from_gray(rq_gray);
    // occupancy in narrow words against the read count scaled by four
    assign level     = wptr - {rq_bin, {LANE_BITS{1'b0}}};
    assign full_core = (level == nptr_t'(NARROW_DEPTH));
    assign full      = full_core | ~ready;
    assign accept    = wr_en & ~full;
    assign wnext     = wptr + nptr_t'(accept);

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wptr     <= '0;
            wq_gray  <= '0;
            hold_cnt <= '0;
            ready    <= 1'b0;
        end else begin
            wptr    <= wnext;
            wq_gray <= to_gray(wnext[NARROW_AW:LANE_BITS]);
            if (!ready) begin
                hold_cnt <= hold_cnt + 1'b1;
                if (hold_cnt == HC_W'(HOLD_CYCLES - 1)) ready <= 1'b1;
            end
        end
    end

    assign beat = '{en:   accept,
                    row:  wptr[NARROW_AW-1:LANE_BITS],
                    lane: wptr[LANE_BITS-1:0],
                    data: wr_data};

    // R3: the writer never runs more than one full store ahead of the reader
    assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        level <= nptr_t'(NARROW_DEPTH))
        else $error("write side exceeded capacity");

    // R7: a write-side clear leaves the pointer at zero and blocks writes
    assert_clear_blocks_R7: assert property (@(posedge wr_clk)
        wr_rst |=> (wptr == '0) && full);
endmodule

// File: rtl/lpf_rd_side.sv
module lpf_rd_side
    import lane_pack_pkg::*;
(
    input  logic               rd_clk,
    input  logic               rd_rst,
    input  logic               rd_en,
    input  wptr_t              wq_gray,
    output logic               empty,
    output logic               take,
    output logic [WIDE_AW-1:0] raddr,
    output wptr_t              rq_gray
);
    wptr_t rptr;
    wptr_t rnext;
    wptr_t wq_bin;
    wptr_t level;

    assign wq_bin = from_gray(wq_gray);
    assign empty  = (rptr == wq_bin);
    assign take   = rd_en & ~empty;
    assign rnext  = rptr + wptr_t'(take);
    assign raddr  = rptr[WIDE_AW-1:0];
    assign level  = wq_bin - rptr;

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rptr    <= '0;
            rq_gray <= '0;
        end else begin
            rptr    <= rnext;
            rq_gray <= to_gray(rnext);
        end
    end

    // R4: the reader never passes the synchronized count of complete words
    assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        level <= wptr_t'(WIDE_DEPTH))
        else $error("read side passed the writer");
endmodule

// File: rtl/lpf_store.sv
module lpf_store
    import lane_pack_pkg::*;
(
    input  logic               wr_clk,
    input  lane_wr_t           beat,
    input  logic               rd_clk,
    input  logic               rd_rst,
    input  logic               take,
    input  logic [WIDE_AW-1:0] raddr,
    output logic [WIDE_W-1:0]  rd_q
);
    logic [WIDE_W-1:0] mem [WIDE_DEPTH];

    always_ff @(posedge wr_clk) begin
        if (beat.en) begin
            mem[beat.row][int'(beat.lane) * NARROW_W +: NARROW_W] <= beat.data;
        end
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst)    rd_q <= '0;
        else if (take) rd_q <= mem[raddr];
    end
endmodule

// File: rtl/lane_pack_fifo.sv
module lane_pack_fifo
    import lane_pack_pkg::*;
#(
    parameter int SYNC_STAGES = 5,
    parameter int CLR_STAGES  = 2,
    parameter int HOLD_CYCLES = 4
) (
    input  logic                wr_clk,
    input  logic                rd_clk,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [NARROW_W-1:0] wr_data,
    output logic                wr_full,
    input  logic                rd_en,
    output logic [WIDE_W-1:0]   rd_data,
    output logic                rd_empty
);
    logic               wr_rst;
    logic               rd_rst;
    lane_wr_t           beat;
    wptr_t              wq_gray_src;
    wptr_t              wq_gray_dst;
    wptr_t              rq_gray_src;
    wptr_t              rq_gray_dst;
    logic               take;
    logic [WIDE_AW-1:0] raddr;

    lpf_rst_sync #(.STAGES(CLR_STAGES)) u_wr_rst (
        .clk(wr_clk), .arst(clr), .srst(wr_rst));

    lpf_rst_sync #(.STAGES(CLR_STAGES)) u_rd_rst (
        .clk(rd_clk), .arst(clr), .srst(rd_rst));

    lpf_wr_side #(.HOLD_CYCLES(HOLD_CYCLES)) u_wr (
        .wr_clk  (wr_clk),
        .wr_rst  (wr_rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rq_gray (rq_gray_dst),
        .full    (wr_full),
        .beat    (beat),
        .wq_gray (wq_gray_src)
    );

    lpf_ptr_sync #(.STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wq_gray_src), .q(wq_gray_dst));

    lpf_ptr_sync #(.STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rq_gray_src), .q(rq_gray_dst));

    lpf_rd_side u_rd (
        .rd_clk  (rd_clk),
        .rd_rst  (rd_rst),
        .rd_en   (rd_en),
        .wq_gray (wq_gray_dst),
        .empty   (rd_empty),
        .take    (take),
        .raddr   (raddr),
        .rq_gray (rq_gray_src)
    );

    lpf_store u_mem (
        .wr_clk (wr_clk),
        .beat   (beat),
        .rd_clk (rd_clk),
        .rd_rst (rd_rst),
        .take   (take),
        .raddr  (raddr),
        .rd_q   (rd_data)
    );

    // R2: output register moves only on an accepted read
    assert_hold_data_R2: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(rd_en && !rd_empty) |=> $stable(rd_data));

    // R7: read side comes out of clear empty with a zero output
    assert_clear_state_R7: assert property (@(posedge rd_clk) disable iff (clr)
        rd_rst |=> rd_empty && (rd_data == '0));
endmodule

// File: tb/lane_pack_fifo_tb_top.sv
module lane_pack_fifo_tb_top;
    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        clr;
    logic        wr_en;
    logic [8:0]  wr_data;
    logic        wr_full;
    logic        rd_en;
    logic [35:0] rd_data;
    logic        rd_empty;

    int n_chk = 0;
    int n_err = 0;
    logic [8:0] sb[$];

    always #10 wr_clk = ~wr_clk;
    always #15 rd_clk = ~rd_clk;

    lane_pack_fifo dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .clr(clr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty));

    task automatic check(input bit ok, input string req,
                         input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // expected wide word: earliest narrow word in the lowest lane (R1)
    function automatic logic [35:0] pop_wide();
        logic [35:0] w;
        for (int l = 0; l < 4; l++) w[l*9 +: 9] = sb.pop_front();
        return w;
    endfunction

    task automatic wr_word(input logic [8:0] d);
        bit done = 0;
        while (!done) begin
            @(negedge wr_clk);
            if (!wr_full) begin
                wr_en = 1'b1; wr_data = d; sb.push_back(d); done = 1;
            end else wr_en = 1'b0;
        end
    endtask

    task automatic wr_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk); wr_en = 1'b0;
        end
    endtask

    task automatic rd_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk); rd_en = 1'b0;
        end
    endtask

    task automatic rd_word(input string req);
        bit done = 0;
        logic [35:0] exp;
        while (!done) begin
            @(negedge rd_clk);
            if (!rd_empty) begin rd_en = 1'b1; exp = pop_wide(); done = 1; end
            else rd_en = 1'b0;
        end
        @(negedge rd_clk); rd_en = 1'b0;
        check(rd_data === exp, req, rd_data, exp);
    endtask

    initial begin
        #(20ns * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [35:0] hold;
        void'($urandom(32'd5150));
        clr = 1'b1; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;

        // reset state (R7)
        wr_idle(10);
        check(wr_full === 1'b1, "R7 full during clear", 36'(wr_full), 36'd1);
        check(rd_empty === 1'b1, "R7 empty during clear", 36'(rd_empty), 36'd1);
        check(rd_data === '0, "R7 data zero", rd_data, '0);
        @(negedge wr_clk); clr = 1'b0;
        wr_idle(20);
        check(wr_full === 1'b0, "R7 full released", 36'(wr_full), 36'd0);

        // partial wide word stays invisible (R5)
        wr_word(9'h101); wr_word(9'h0A2); wr_word(9'h1C3); wr_idle(1);
        rd_idle(40);
        check(rd_empty === 1'b1, "R5 three lanes not readable", 36'(rd_empty), 36'd1);
        wr_word(9'h0E4); wr_idle(1);
        rd_idle(20);
        check(rd_empty === 1'b0, "R5 fourth lane completes word", 36'(rd_empty), 36'd0);
        // explicit lane positions (R1)
        check(sb[0] == 9'h101 && sb[3] == 9'h0E4, "R1 queue order", 36'(sb[3]), 36'h0E4);
        rd_word("R1 lane packing");
        hold = rd_data;

        // underflow (R4) and hold (R2)
        rd_idle(20);
        check(rd_data === hold, "R2 data held while idle", rd_data, hold);
        @(negedge rd_clk); rd_en = 1'b1;
        rd_idle(3);
        check(rd_data === hold && rd_empty === 1'b1, "R4 read on empty dropped", rd_data, hold);

        // fill to capacity (R6)
        for (int i = 0; i < 8192; i++) begin
            if (i == 8191) check(wr_full === 1'b0, "R6 not full before last", 36'(wr_full), 36'd0);
            wr_word(9'((i * 37 + 5) & 9'h1FF));
        end
        wr_idle(1);
        check(wr_full === 1'b1, "R6 full at capacity", 36'(wr_full), 36'd1);

        // one read frees four lanes (R8)
        rd_word("R8 read from full");
        wr_idle(30);
        check(wr_full === 1'b0, "R8 full falls after read", 36'(wr_full), 36'd0);
        for (int i = 0; i < 4; i++) wr_word(9'(9'h150 + i));
        wr_idle(1);
        check(wr_full === 1'b1, "R8 full again after four", 36'(wr_full), 36'd1);

        // overflow attempts (R3)
        for (int i = 0; i < 6; i++) begin
            @(negedge wr_clk); wr_en = 1'b1; wr_data = 9'h1AB;
        end
        wr_idle(1);
        for (int i = 0; i < 2048; i++) rd_word("R3 contents after overflow attempt");
        rd_idle(3);
        check(rd_empty === 1'b1, "R3 no extra word stored", 36'(rd_empty), 36'd1);

        // clear while holding data, writes during and after clear (R7)
        for (int i = 0; i < 8; i++) wr_word(9'(i + 9'h60));
        wr_idle(1); rd_idle(20);
        @(negedge wr_clk); clr = 1'b1; wr_en = 1'b1; wr_data = 9'h0F0;
        wr_idle(0);
        for (int i = 0; i < 5; i++) begin @(negedge wr_clk); wr_en = 1'b1; end
        check(wr_full === 1'b1, "R7 full while clear", 36'(wr_full), 36'd1);
        rd_idle(4);
        check(rd_empty === 1'b1 && rd_data === '0, "R7 cleared read side", rd_data, '0);
        @(negedge wr_clk); clr = 1'b0; wr_en = 1'b1;
        @(negedge wr_clk);
        check(wr_full === 1'b1, "R7 hold window blocks writes", 36'(wr_full), 36'd1);
        sb.delete();
        wr_idle(30); rd_idle(10);
        check(rd_empty === 1'b1, "R7 writes in clear dropped", 36'(rd_empty), 36'd1);

        // random concurrent traffic (R1, R2)
        fork
            begin
                for (int i = 0; i < 1600; i++) begin
                    if ($urandom % 4 == 0) wr_idle(1 + $urandom % 3);
                    wr_word(9'($urandom));
                end
                wr_idle(1);
            end
            begin
                int got = 0;
                bit pend = 0;
                logic [35:0] exp = '0;
                while (got < 400 || pend) begin
                    @(negedge rd_clk);
                    if (pend) check(rd_data === exp, "R1 random order", rd_data, exp);
                    pend = 0;
                    if (got < 400 && ($urandom % 3 != 0)) begin
                        rd_en = 1'b1;
                        if (!rd_empty) begin exp = pop_wide(); pend = 1; got++; end
                    end else rd_en = 1'b0;
                end
                rd_en = 1'b0;
            end
        join
        rd_idle(3);
        check(rd_empty === 1'b1, "R2 drained after random", 36'(rd_empty), 36'd1);
        finish_run();
    end
endmodule